// File: doc/BRIEF.md
# Hash Message Schedule Expander

This block turns one 512-bit message block into the 64 word pairs that the rounds of a 64-round hash compression consume, one pair per accepted handshake. Each pair is the expanded word W[t] and its companion W'[t] = W[t] ^ W[t+4]. The block never holds all 68 expanded words. A 16-word shift window holds W[t] through W[t+15]. Each time the round engine takes a pair, the window moves by one word and a freshly computed word enters at the top. This keeps the window four words ahead of the round index, which is what W'[t] needs.

A block is taken on the input side when `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so a second block can never overwrite one that is still being expanded. On the output side, a pair is presented with `out_valid`. The round engine may hold `out_ready` low for any number of cycles, and during that time the pair and its index stay frozen. After the pair for round 63 is taken, `done` pulses for one cycle and the block goes back to idle, ready for the next message block.

Top module: `msg_sched_expander`

## Requirements
- R1: `in_block` carries the 64 message bytes in memory order, with byte j at bits [8j+7:8j]. Message word k is built from bytes 4k, 4k+1, 4k+2 and 4k+3, and byte 4k becomes the most significant byte. For example, a block whose byte j equals j gives word 0 = 0x00010203 and word 1 = 0x04050607.
- R2: For rounds t = 0 to 15, `out_w` equals message word t, taken in order.
- R3: For 16 <= t <= 67, W[t] = Q(W[t-16] ^ W[t-9] ^ rotl(W[t-3],15)) ^ rotl(W[t-13],7) ^ W[t-6], where Q(x) = x ^ rotl(x,15) ^ rotl(x,23). `out_w` for rounds 16 to 63 equals this W[t].
- R4: `out_wp` equals W[t] ^ W[t+4] for every round 0 to 63. Rounds 60 to 63 therefore depend on W[64] to W[67].
- R5: While `out_valid` is high and `out_ready` is low, `out_w`, `out_wp` and `out_idx` hold their values into the next cycle.
- R6: `in_ready` is high exactly when `out_valid` is low. A block presented while the expander is busy is ignored: the pairs that are streaming out do not change.
- R7: `out_idx` is 0 for the first pair after a block is accepted and rises by one with each accepted pair, up to 63, giving exactly 64 pairs.
- R8: One cycle after the pair for round 63 is accepted, `done` is high for exactly one cycle, `out_valid` is low and `in_ready` is high.
- R9: A synchronous active-high `rst` leaves `out_valid` low, `in_ready` high, `done` low and `out_idx` at 0, even when it is applied in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A message block is offered |
| in_ready | output | 1 | The expander is idle and will take a block |
| in_block | input | 512 | Message bytes in memory order, byte j at [8j+7:8j] |
| out_valid | output | 1 | A word pair is presented |
| out_ready | input | 1 | The round engine takes the presented pair |
| out_w | output | 32 | Expanded word W[t] |
| out_wp | output | 32 | Companion word W[t] ^ W[t+4] |
| out_idx | output | 6 | Round index t of the presented pair |
| done | output | 1 | One-cycle pulse after the last pair is taken |

## Verification
The bench builds the block with its default of 64 rounds. Every block therefore runs the full expansion, up to the words W[64] to W[67] that only the companion outputs of the last four rounds reveal. A counting-pattern block pins down the byte order. All-zero and all-one blocks exercise the rotation mix at its extremes. Random blocks are driven with random back-pressure, so every round index is seen both stalled and flowing. A rival block offered while the expander is busy, and a reset in the middle of a block, reach the ignore and recovery paths.

// File: rtl/msg_sched_pkg.sv
package msg_sched_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int WIN      = 16;
  localparam int LEAD     = 4;
  localparam int BLOCK_W  = WORD_W * WIN;
  localparam int BYTES_PW = WORD_W / BYTE_W;

  // window taps relative to W[t], for forming W[t+16]
  localparam int TAP_OLD  = 0;
  localparam int TAP_M9   = 7;
  localparam int TAP_M3   = 13;
  localparam int TAP_M13  = 3;
  localparam int TAP_M6   = 10;

  localparam int ROT_A    = 15;
  localparam int ROT_B    = 7;
  localparam int PERM_R1  = 15;
  localparam int PERM_R2  = 23;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t perm_q(input word_t x);
    return x ^ rotl(x, PERM_R1) ^ rotl(x, PERM_R2);
  endfunction
endpackage

// File: rtl/sched_unpack.sv
module sched_unpack
  import msg_sched_pkg::*;
(
  input  logic [BLOCK_W-1:0]         blk,
  output logic [WIN-1:0][WORD_W-1:0] words
);
  // Each word takes its first memory byte as the most significant byte.
  for (genvar k = 0; k < WIN; k++) begin : g_word
    for (genvar b = 0; b < BYTES_PW; b++) begin : g_byte
      assign words[k][WORD_W-1-b*BYTE_W -: BYTE_W] = blk[(k*BYTES_PW+b)*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/sched_next.sv
module sched_next
  import msg_sched_pkg::*;
(
  input  logic [WIN-1:0][WORD_W-1:0] win,
  output word_t                      nxt
);
  word_t mix;
  always_comb begin
    mix = win[TAP_OLD] ^ win[TAP_M9] ^ rotl(win[TAP_M3], ROT_A);
    nxt = perm_q(mix) ^ rotl(win[TAP_M13], ROT_B) ^ win[TAP_M6];
  end
endmodule

// File: rtl/sched_window.sv
module sched_window
  import msg_sched_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       shift,
  input  logic [WIN-1:0][WORD_W-1:0] load_words,
  input  word_t                      fresh,
  output logic [WIN-1:0][WORD_W-1:0] win
);
  for (genvar i = 0; i < WIN; i++) begin : g_slot
    word_t upper;
    if (i == WIN-1) begin : g_top
      assign upper = fresh;
    end else begin : g_mid
      assign upper = win[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)        win[i] <= '0;
      else if (load)  win[i] <= load_words[i];
      else if (shift) win[i] <= upper;
    end
  end

  // R5: a move only happens on a taken pair
  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> $stable(win));
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl #(
  parameter int ROUNDS = 64,
  localparam int IDX_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load,
  output logic             shift,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS-1);
  logic busy;

  assign out_valid = busy;
  assign in_ready  = !busy;
  assign load      = in_valid && !busy;
  assign shift     = busy && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (shift) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assert_start_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && idx == '0));
  assert_step_one_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && idx != LAST) |=> (out_valid && idx == $past(idx) + 1'b1));
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && idx == LAST) |=> (done && in_ready && !out_valid));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_ready_excl_R6: assert property (@(posedge clk) disable iff (rst)
    in_ready != out_valid);
endmodule

// File: rtl/msg_sched_expander.sv
module msg_sched_expander
  import msg_sched_pkg::*;
#(
  parameter int ROUNDS = 64,
  localparam int IDX_W = $clog2(ROUNDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BLOCK_W-1:0] in_block,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_w,
  output logic [WORD_W-1:0]  out_wp,
  output logic [IDX_W-1:0]   out_idx,
  output logic               done
);
  logic [WIN-1:0][WORD_W-1:0] msg_words;
  logic [WIN-1:0][WORD_W-1:0] win;
  word_t                      fresh;
  logic                       load, shift;

  sched_unpack u_unpack (.blk(in_block), .words(msg_words));

  sched_next u_next (.win(win), .nxt(fresh));

  sched_window u_win (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .load_words(msg_words), .fresh(fresh), .win(win)
  );

  sched_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load(load), .shift(shift),
    .idx(out_idx), .done(done)
  );

  assign out_w  = win[0];
  assign out_wp = win[0] ^ win[LEAD];

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_w) && $stable(out_wp) && $stable(out_idx)));
  assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && in_valid) |=> $stable(out_w));
endmodule

// File: tb/sim_msg_sched_expander.sv
module sim_msg_sched_expander;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [511:0] in_block;
  logic         out_valid;
  logic         out_ready;
  logic [31:0]  out_w, out_wp;
  logic [5:0]   out_idx;
  logic         done;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] wexp [68];

  always #10 clk = ~clk;

  msg_sched_expander u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .out_valid(out_valid), .out_ready(out_ready),
    .out_w(out_w), .out_wp(out_wp), .out_idx(out_idx), .done(done)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic void model(input logic [511:0] b);
    for (int k = 0; k < 16; k++)
      wexp[k] = {b[32*k +: 8], b[32*k+8 +: 8], b[32*k+16 +: 8], b[32*k+24 +: 8]};
    for (int t = 16; t < 68; t++) begin
      logic [31:0] m;
      m = wexp[t-16] ^ wexp[t-9] ^ rl(wexp[t-3], 15);
      wexp[t] = (m ^ rl(m, 15) ^ rl(m, 23)) ^ rl(wexp[t-13], 7) ^ wexp[t-6];
    end
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] rnd_block();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  // run one block; stall_pct is the chance (0..100) of out_ready low per cycle
  task automatic run_block(input logic [511:0] b, input int stall_pct, input bit rival);
    int t;
    model(b);
    @(negedge clk);
    chk("R6 in_ready idle", {63'd0, in_ready}, 64'd1);
    in_block = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    t = 0;
    while (t < 64) begin
      bit rdy;
      chk("R7 out_valid", {63'd0, out_valid}, 64'd1);
      chk("R6 in_ready busy", {63'd0, in_ready}, 64'd0);
      chk("R7 idx", {58'd0, out_idx}, 64'(t));
      chk(t < 16 ? "R2 out_w" : "R3 out_w", {32'd0, out_w}, {32'd0, wexp[t]});
      chk("R4 out_wp", {32'd0, out_wp}, {32'd0, wexp[t] ^ wexp[t+4]});
      rdy = (($urandom % 100) >= stall_pct);
      out_ready = rdy;
      if (rival) begin
        in_valid = $urandom % 2;
        in_block = rnd_block();
      end
      @(negedge clk);
      if (rdy) t++;
    end
    out_ready = 1'b0;
    in_valid  = 1'b0;
    chk("R8 done", {63'd0, done}, 64'd1);
    chk("R8 out_valid low", {63'd0, out_valid}, 64'd0);
    chk("R8 in_ready back", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    chk("R8 done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    logic [511:0] b;
    void'($urandom(32'h5eed1234));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_block = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 reset in_ready", {63'd0, in_ready}, 64'd1);
    chk("R9 reset done", {63'd0, done}, 64'd0);
    chk("R9 reset idx", {58'd0, out_idx}, 64'd0);

    // R1 byte ordering with a counting pattern
    for (int j = 0; j < 64; j++) b[8*j +: 8] = 8'(j);
    in_block = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 word0", {32'd0, out_w}, 64'h00010203);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R1 word1", {32'd0, out_w}, 64'h04050607);
    out_ready = 1'b0;
    // R9 reset in the middle of a block
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 mid reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 mid reset in_ready", {63'd0, in_ready}, 64'd1);
    chk("R9 mid reset idx", {58'd0, out_idx}, 64'd0);

    run_block(b, 0, 1'b0);
    run_block('0, 30, 1'b0);
    run_block({512{1'b1}}, 0, 1'b0);
    run_block(rnd_block(), 50, 1'b1);   // R6 rival block while busy
    for (int r = 0; r < 8; r++) run_block(rnd_block(), 40, r[0]);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule